// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block performs the entry half of an interrupt for a 16-bit segmented processor model. A request comes either from an external interrupt controller (a level request, answered with an acknowledge pulse, after which the controller puts the vector number on its bus) or from a software interrupt instruction that supplies the vector number with the request. The sequencer pushes the interrupted code segment and instruction pointer onto the stack, fetches the handler's offset and segment from the vector table, and presents the new code segment, instruction pointer and stack pointer together with a one-cycle done pulse.

Every stack access uses a 20-bit physical address formed as the 16-bit segment shifted left by four plus the 16-bit offset. The memory port is byte wide and synchronous: one access per cycle, with read data returned on the cycle after the request. The vector table is located by a physical base address and a byte length. A vector whose entry does not fit inside that length ends the sequence with a fault pulse before any memory access.

Top module: `intr_entry_seq`

## Requirements
- R1: A stack byte address is ((segment << 4) + offset) taken modulo 2^20, where the offset itself is computed modulo 2^16.
- R2: In the idle state a software request is taken in the cycle it is high, using sw_vec_i as the vector; when software and hardware requests are high in the same cycle the software request wins and no acknowledge is produced.
- R3: A hardware request taken in the idle state yields hw_ack_o high for exactly one cycle, in the cycle after the request is sampled; hw_vec_i is sampled in the cycle after that acknowledge and its earlier values have no effect.
- R4: Before any table read, four byte writes go out in this order: CS low byte at SS:(SP-2), CS high byte at SS:(SP-1), IP low byte at SS:(SP-4), IP high byte at SS:(SP-3).
- R5: The table entry for vector v is four bytes at physical address base + 4*v: bytes 0 and 1 are the handler offset (low byte first), bytes 2 and 3 the handler segment (low byte first); they are read in ascending address order.
- R6: done_o is a one-cycle pulse; while it is high cs_o and ip_o hold the handler segment and offset and sp_o holds SP-4. It rises 11 cycles after a software request is sampled and 12 cycles after a hardware request is sampled.
- R7: If 4*v+4 exceeds tbl_len_i, fault_o pulses one cycle (2 cycles after a software request is sampled, 3 after a hardware one), no memory access is made, no done pulse occurs, and cs_o, ip_o, sp_o keep their previous values.
- R8: busy_o is high from the cycle after a request is taken until the sequence ends; requests of either kind arriving while busy are ignored and produce no acknowledge, memory access or extra done pulse.
- R9: After reset busy_o, done_o, fault_o, hw_ack_o, mem_req_o are low and cs_o, ip_o, sp_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 1 | Interrupt request from the controller, level |
| hw_vec_i | input | 8 | Vector number from the controller, valid the cycle after hw_ack_o |
| hw_ack_o | output | 1 | Acknowledge pulse to the controller |
| sw_req_i | input | 1 | Software interrupt request |
| sw_vec_i | input | 8 | Immediate vector number of the software request |
| tbl_base_i | input | 20 | Physical base address of the vector table |
| tbl_len_i | input | 16 | Vector table length in bytes |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable, qualifies mem_req_o |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 8 | Write data byte |
| mem_rdata_i | input | 8 | Read data byte, returned the cycle after a read request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | New CS:IP valid, one-cycle pulse |
| fault_o | output | 1 | Vector outside table, one-cycle pulse |
| cs_o | output | 16 | New code segment |
| ip_o | output | 16 | New instruction pointer |
| sp_o | output | 16 | New stack pointer |

## Verification
The hardest situations to reach are the ones where arithmetic wraps: a stack pointer so low that the pushed bytes straddle offset zero, and a stack segment so high that segment plus offset passes the top of the 20-bit space. The bench sets SP to 1 for the first and SS to 0xFFFF for the second and checks every write address. Timing of the controller handshake is probed by holding a wrong vector on hw_vec_i until the acknowledge is seen, and requests are injected mid-sequence to prove they are dropped.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HWVEC,
    ST_CHECK,
    ST_PUSH_CS_LO,
    ST_PUSH_CS_HI,
    ST_PUSH_IP_LO,
    ST_PUSH_IP_HI,
    ST_RD_B0,
    ST_RD_B1,
    ST_RD_B2,
    ST_RD_B3,
    ST_FIN
  } seq_state_e;

  localparam int ENTRY_BYTES = 4;
  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/intr_phys_addr.sv
module intr_phys_addr #(
  parameter int SEG_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SEG_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int FULL_W = SEG_W + SHIFT;
  localparam int SUM_W  = ((FULL_W > ADDR_W) ? FULL_W : ADDR_W) + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = SUM_W'({seg_i, {SHIFT{1'b0}}}) + SUM_W'(off_i);
    addr_o = sum[ADDR_W-1:0];  // wraps at the top of physical space
  end
endmodule

// File: rtl/intr_vec_src.sv
module intr_vec_src #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             hw_req_i,
  input  logic [VEC_W-1:0] hw_vec_i,
  input  logic             sw_req_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  output logic             take_sw_o,
  output logic             take_hw_o,
  output logic             hw_ack_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;

  // software source has priority: it belongs to the instruction in flight
  assign take_sw_o = idle_i & sw_req_i;
  assign take_hw_o = idle_i & hw_req_i & ~sw_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take_hw_o;
      if (take_sw_o)  vec_q <= sw_vec_i;
      else if (ack_q) vec_q <= hw_vec_i;
    end
  end

  assign hw_ack_o = ack_q;
  assign vec_o    = vec_q;

  assert_ack_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_ack_o |=> !hw_ack_o);

  assert_ack_follows_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hw_o |=> hw_ack_o);
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_sw_i,
  input  logic              take_hw_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [LEN_W-1:0]  tbl_len_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] stk_seg_o,
  output logic [WORD_W-1:0] stk_off_o,
  input  logic [ADDR_W-1:0] stk_addr_i,
  output logic              idle_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              done_o,
  output logic              fault_o
);
  localparam int IDX_W = VEC_W + ENTRY_SHIFT;
  localparam int CMP_W = ((IDX_W > LEN_W) ? IDX_W : LEN_W) + 1;
  localparam int HALF  = WORD_W / 2;

  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] cs_q, ip_q, ss_q, sp_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        ent_b0_q, ent_b1_q, ent_b2_q;
  logic [WORD_W-1:0] cs_r, ip_r, sp_r;
  logic              done_r, fault_r;

  logic [CMP_W-1:0]  ent_end;
  logic              out_of_table;
  logic [1:0]        rd_idx;
  logic              rd_state;
  logic [ADDR_W-1:0] tbl_addr;

  // entry must lie fully inside the table
  always_comb begin
    ent_end      = CMP_W'({vec_i, {ENTRY_SHIFT{1'b0}}}) + CMP_W'(ENTRY_BYTES);
    out_of_table = ent_end > CMP_W'(len_q);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (take_sw_i) state_d = ST_CHECK;
                     else if (take_hw_i) state_d = ST_HWVEC;
      ST_HWVEC:      state_d = ST_CHECK;
      ST_CHECK:      state_d = out_of_table ? ST_IDLE : ST_PUSH_CS_LO;
      ST_PUSH_CS_LO: state_d = ST_PUSH_CS_HI;
      ST_PUSH_CS_HI: state_d = ST_PUSH_IP_LO;
      ST_PUSH_IP_LO: state_d = ST_PUSH_IP_HI;
      ST_PUSH_IP_HI: state_d = ST_RD_B0;
      ST_RD_B0:      state_d = ST_RD_B1;
      ST_RD_B1:      state_d = ST_RD_B2;
      ST_RD_B2:      state_d = ST_RD_B3;
      ST_RD_B3:      state_d = ST_FIN;
      ST_FIN:        state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      base_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && (take_sw_i || take_hw_i)) begin
        cs_q   <= cs_i;
        ip_q   <= ip_i;
        ss_q   <= ss_i;
        sp_q   <= sp_i;
        base_q <= tbl_base_i;
        len_q  <= tbl_len_i;
      end
    end
  end

  // stack offsets: CS word at SP-2, IP word at SP-4
  always_comb begin
    stk_off_o = sp_q;
    unique case (state_q)
      ST_PUSH_CS_LO: stk_off_o = sp_q - WORD_W'(2);
      ST_PUSH_CS_HI: stk_off_o = sp_q - WORD_W'(1);
      ST_PUSH_IP_LO: stk_off_o = sp_q - WORD_W'(4);
      ST_PUSH_IP_HI: stk_off_o = sp_q - WORD_W'(3);
      default:       stk_off_o = sp_q;
    endcase
  end
  assign stk_seg_o = ss_q;

  always_comb begin
    rd_state = 1'b1;
    rd_idx   = 2'd0;
    unique case (state_q)
      ST_RD_B0: rd_idx = 2'd0;
      ST_RD_B1: rd_idx = 2'd1;
      ST_RD_B2: rd_idx = 2'd2;
      ST_RD_B3: rd_idx = 2'd3;
      default:  rd_state = 1'b0;
    endcase
    tbl_addr = base_q + ADDR_W'({vec_i, {ENTRY_SHIFT{1'b0}}}) + ADDR_W'(rd_idx);
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = stk_addr_i;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_CS_LO: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = cs_q[HALF-1:0];      end
      ST_PUSH_CS_HI: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = cs_q[WORD_W-1:HALF]; end
      ST_PUSH_IP_LO: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = ip_q[HALF-1:0];      end
      ST_PUSH_IP_HI: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = ip_q[WORD_W-1:HALF]; end
      default: begin
        if (rd_state) begin
          mem_req_o  = 1'b1;
          mem_addr_o = tbl_addr;
        end
      end
    endcase
  end

  // read data arrives one cycle after its request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_b0_q <= '0;
      ent_b1_q <= '0;
      ent_b2_q <= '0;
      cs_r     <= '0;
      ip_r     <= '0;
      sp_r     <= '0;
      done_r   <= 1'b0;
      fault_r  <= 1'b0;
    end else begin
      done_r  <= 1'b0;
      fault_r <= 1'b0;
      unique case (state_q)
        ST_RD_B1: ent_b0_q <= mem_rdata_i;
        ST_RD_B2: ent_b1_q <= mem_rdata_i;
        ST_RD_B3: ent_b2_q <= mem_rdata_i;
        ST_FIN: begin
          ip_r   <= {ent_b1_q, ent_b0_q};
          cs_r   <= {mem_rdata_i, ent_b2_q};
          sp_r   <= sp_q - WORD_W'(4);
          done_r <= 1'b1;
        end
        ST_CHECK: fault_r <= out_of_table;
        default: ;
      endcase
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign busy_o  = ~idle_o;
  assign cs_o    = cs_r;
  assign ip_o    = ip_r;
  assign sp_o    = sp_r;
  assign done_o  = done_r;
  assign fault_o = fault_r;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_fault_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  assert_fault_no_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !$past(mem_req_o));

  assert_fault_keeps_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(sp_o));

  assert_mem_only_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_reads_after_writes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && !$past(mem_req_o)) |-> 1'b0);
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LEN_W  = 16,
  parameter int SHIFT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_req_i,
  input  logic [VEC_W-1:0]  hw_vec_i,
  output logic              hw_ack_o,
  input  logic              sw_req_i,
  input  logic [VEC_W-1:0]  sw_vec_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [LEN_W-1:0]  tbl_len_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o
);
  logic              idle;
  logic              take_sw, take_hw;
  logic [VEC_W-1:0]  vec;
  logic [WORD_W-1:0] stk_seg, stk_off;
  logic [ADDR_W-1:0] stk_addr;

  intr_vec_src #(.VEC_W(VEC_W)) u_vec_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (idle),
    .hw_req_i  (hw_req_i),
    .hw_vec_i  (hw_vec_i),
    .sw_req_i  (sw_req_i),
    .sw_vec_i  (sw_vec_i),
    .take_sw_o (take_sw),
    .take_hw_o (take_hw),
    .hw_ack_o  (hw_ack_o),
    .vec_o     (vec)
  );

  intr_phys_addr #(.SEG_W(WORD_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_stk_addr (
    .seg_i  (stk_seg),
    .off_i  (stk_off),
    .addr_o (stk_addr)
  );

  intr_entry_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .VEC_W(VEC_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_sw_i   (take_sw),
    .take_hw_i   (take_hw),
    .vec_i       (vec),
    .tbl_base_i  (tbl_base_i),
    .tbl_len_i   (tbl_len_i),
    .cs_i        (cs_i),
    .ip_i        (ip_i),
    .ss_i        (ss_i),
    .sp_i        (sp_i),
    .stk_seg_o   (stk_seg),
    .stk_off_o   (stk_off),
    .stk_addr_i  (stk_addr),
    .idle_o      (idle),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .cs_o        (cs_o),
    .ip_o        (ip_o),
    .sp_o        (sp_o),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );
endmodule

// File: tb/intr_entry_seq_bench.sv
`timescale 1ns/1ps
module intr_entry_seq_bench;
  localparam logic [19:0] BASE = 20'h00400;
  localparam logic [15:0] LEN  = 16'h0088;  // vectors 0x00..0x21 fit

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_req = 1'b0, sw_req = 1'b0;
  logic [7:0]  hw_vec = 8'h00, sw_vec = 8'h00;
  logic [15:0] cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic [19:0] tbl_base = BASE;
  logic [15:0] tbl_len = LEN;
  logic        hw_ack, mem_req, mem_we, busy, done, fault;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] cs_out, ip_out, sp_out;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0]  mem [int];
  logic [19:0] wlog_a [0:15];
  logic [7:0]  wlog_d [0:15];
  int wr_n = 0, rd_n = 0, first_rd_after = -1;

  always #10 clk = ~clk;

  intr_entry_seq u_intr_entry_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .hw_req_i(hw_req), .hw_vec_i(hw_vec), .hw_ack_o(hw_ack),
    .sw_req_i(sw_req), .sw_vec_i(sw_vec),
    .tbl_base_i(tbl_base), .tbl_len_i(tbl_len),
    .cs_i(cs_in), .ip_i(ip_in), .ss_i(ss_in), .sp_i(sp_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .fault_o(fault),
    .cs_o(cs_out), .ip_o(ip_out), .sp_o(sp_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (mem_req) begin
      if (mem_we) begin
        mem[int'(mem_addr)] = mem_wdata;
        if (wr_n < 16) begin wlog_a[wr_n] = mem_addr; wlog_d[wr_n] = mem_wdata; end
        wr_n++;
      end else begin
        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        if (rd_n == 0) first_rd_after = wr_n;
        rd_n++;
      end
    end
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    return s[19:0];
  endfunction

  function automatic logic [15:0] ent_ip(input logic [7:0] v); return 16'h1200 + {v, v}; endfunction
  function automatic logic [15:0] ent_cs(input logic [7:0] v); return 16'hC000 ^ {v, 8'h5A}; endfunction

  task automatic put_entry(input logic [7:0] v);
    int a;
    a = int'(BASE) + 4 * int'(v);
    mem[a]     = ent_ip(v)[7:0];
    mem[a + 1] = ent_ip(v)[15:8];
    mem[a + 2] = ent_cs(v)[7:0];
    mem[a + 3] = ent_cs(v)[15:8];
  endtask

  // drives one request from a negedge and watches until done/fault
  task automatic run_int(input bit hw, input bit both, input logic [7:0] vec,
                         input logic [15:0] cs, ip, ss, sp, input int inject,
                         output int lat, output bit got_done, output bit got_fault,
                         output int acks, output int ack_at, output int done_w);
    wr_n = 0; rd_n = 0; first_rd_after = -1;
    cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
    lat = 0; got_done = 0; got_fault = 0; acks = 0; ack_at = -1; done_w = 0;
    if (hw) begin hw_req = 1'b1; hw_vec = 8'hEE; end
    else begin sw_req = 1'b1; sw_vec = vec; if (both) begin hw_req = 1'b1; hw_vec = 8'hEE; end end
    for (int k = 1; k <= 40 && !got_done && !got_fault; k++) begin
      @(negedge clk);
      if (!hw) begin sw_req = 1'b0; hw_req = 1'b0; end
      if (hw_ack) begin
        acks++; if (ack_at < 0) ack_at = k;
        hw_req = 1'b0; hw_vec = vec;
      end
      if (k == inject) begin sw_req = 1'b1; sw_vec = 8'h01; hw_req = 1'b1; end
      else if (k == inject + 1) begin sw_req = 1'b0; hw_req = 1'b0; end
      if (done) begin got_done = 1; lat = k; done_w = 1; end
      if (fault) begin got_fault = 1; lat = k; end
    end
    hw_vec = 8'hEE;
  endtask

  task automatic expect_entry(input string tag, input logic [7:0] v,
                              input logic [15:0] cs, ip, ss, sp,
                              input int lat, input int exp_lat, input bit got_done);
    logic [15:0] s;
    s = sp;
    chk(got_done, "R6", {tag, " done seen"}, 32'(got_done), 32'd1);
    chk(lat == exp_lat, "R6", {tag, " done latency"}, 32'(lat), 32'(exp_lat));
    chk(cs_out == ent_cs(v), "R5", {tag, " new CS"}, 32'(cs_out), 32'(ent_cs(v)));
    chk(ip_out == ent_ip(v), "R5", {tag, " new IP"}, 32'(ip_out), 32'(ent_ip(v)));
    chk(sp_out == 16'(s - 16'd4), "R6", {tag, " new SP"}, 32'(sp_out), 32'(16'(s - 16'd4)));
    chk(wr_n == 4, "R4", {tag, " write count"}, 32'(wr_n), 32'd4);
    chk(rd_n == 4 && first_rd_after == 4, "R5", {tag, " reads after writes"}, 32'(rd_n), 32'd4);
    chk(wlog_a[0] == phys(ss, 16'(s - 16'd2)) && wlog_d[0] == cs[7:0], "R4", {tag, " CS low push"},
        {4'h0, wlog_a[0], wlog_d[0]}, {4'h0, phys(ss, 16'(s - 16'd2)), cs[7:0]});
    chk(wlog_a[1] == phys(ss, 16'(s - 16'd1)) && wlog_d[1] == cs[15:8], "R4", {tag, " CS high push"},
        {4'h0, wlog_a[1], wlog_d[1]}, {4'h0, phys(ss, 16'(s - 16'd1)), cs[15:8]});
    chk(wlog_a[2] == phys(ss, 16'(s - 16'd4)) && wlog_d[2] == ip[7:0], "R4", {tag, " IP low push"},
        {4'h0, wlog_a[2], wlog_d[2]}, {4'h0, phys(ss, 16'(s - 16'd4)), ip[7:0]});
    chk(wlog_a[3] == phys(ss, 16'(s - 16'd3)) && wlog_d[3] == ip[15:8], "R4", {tag, " IP high push"},
        {4'h0, wlog_a[3], wlog_d[3]}, {4'h0, phys(ss, 16'(s - 16'd3)), ip[15:8]});
    @(negedge clk);
    chk(!done, "R6", {tag, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fault && !hw_ack && !mem_req, "R9", "control outputs low after reset",
        {27'h0, busy, done, fault, hw_ack, mem_req}, 32'd0);
    chk(cs_out == 0 && ip_out == 0 && sp_out == 0, "R9", "CS/IP/SP zero after reset",
        {cs_out, ip_out}, 32'd0);
  endtask

  task automatic t_soft;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(0, 0, 8'h10, 16'h3344, 16'h5566, 16'h2000, 16'h0100, -5, lat, gd, gf, acks, ack_at, dw);
    expect_entry("R2 soft vector 0x10", 8'h10, 16'h3344, 16'h5566, 16'h2000, 16'h0100, lat, 11, gd);
    chk(acks == 0, "R2", "no acknowledge for soft request", 32'(acks), 32'd0);
  endtask

  task automatic t_hard;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(1, 0, 8'h07, 16'hABCD, 16'h0F0E, 16'h3000, 16'h0200, -5, lat, gd, gf, acks, ack_at, dw);
    chk(ack_at == 1, "R3", "ack in cycle after request", 32'(ack_at), 32'd1);
    chk(acks == 1, "R3", "ack lasts one cycle", 32'(acks), 32'd1);
    expect_entry("R3 hard vector 0x07", 8'h07, 16'hABCD, 16'h0F0E, 16'h3000, 16'h0200, lat, 12, gd);
  endtask

  task automatic t_both;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(0, 1, 8'h03, 16'h1111, 16'h2222, 16'h0800, 16'h0040, -5, lat, gd, gf, acks, ack_at, dw);
    chk(acks == 0, "R2", "soft wins, no ack", 32'(acks), 32'd0);
    expect_entry("R2 simultaneous", 8'h03, 16'h1111, 16'h2222, 16'h0800, 16'h0040, lat, 11, gd);
  endtask

  task automatic t_boundary;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(0, 0, 8'h21, 16'h0A0B, 16'h0C0D, 16'h0500, 16'h0080, -5, lat, gd, gf, acks, ack_at, dw);
    expect_entry("R7 last fitting vector", 8'h21, 16'h0A0B, 16'h0C0D, 16'h0500, 16'h0080, lat, 11, gd);
  endtask

  task automatic t_fault;
    int lat, acks, ack_at, dw; bit gd, gf;
    logic [15:0] c0, i0, s0;
    c0 = cs_out; i0 = ip_out; s0 = sp_out;
    run_int(0, 0, 8'h22, 16'h7777, 16'h8888, 16'h0600, 16'h0300, -5, lat, gd, gf, acks, ack_at, dw);
    chk(gf && !gd, "R7", "soft fault pulse", {30'h0, gf, gd}, 32'd2);
    chk(lat == 2, "R7", "soft fault latency", 32'(lat), 32'd2);
    chk(wr_n == 0 && rd_n == 0, "R7", "no memory access on fault", 32'(wr_n + rd_n), 32'd0);
    chk(cs_out == c0 && ip_out == i0 && sp_out == s0, "R7", "outputs kept on fault",
        {cs_out, sp_out}, {c0, s0});
    @(negedge clk);
    chk(!fault && !busy, "R7", "fault one cycle, idle", {30'h0, fault, busy}, 32'd0);
    run_int(1, 0, 8'hF0, 16'h7777, 16'h8888, 16'h0600, 16'h0300, -5, lat, gd, gf, acks, ack_at, dw);
    chk(gf && lat == 3, "R7", "hard fault latency", 32'(lat), 32'd3);
  endtask

  task automatic t_sp_wrap;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(0, 0, 8'h11, 16'h4321, 16'h8765, 16'h1000, 16'h0001, -5, lat, gd, gf, acks, ack_at, dw);
    chk(wlog_a[1] == 20'h10000, "R1", "offset wraps to 0", 32'(wlog_a[1]), 32'h10000);
    expect_entry("R1 SP wrap", 8'h11, 16'h4321, 16'h8765, 16'h1000, 16'h0001, lat, 11, gd);
  endtask

  task automatic t_phys_wrap;
    int lat, acks, ack_at, dw; bit gd, gf;
    run_int(1, 0, 8'h12, 16'h0102, 16'h0304, 16'hFFFF, 16'h0024, -5, lat, gd, gf, acks, ack_at, dw);
    chk(wlog_a[0] == 20'h00012, "R1", "20-bit address wraps", 32'(wlog_a[0]), 32'h00012);
    expect_entry("R1 phys wrap", 8'h12, 16'h0102, 16'h0304, 16'hFFFF, 16'h0024, lat, 12, gd);
  endtask

  task automatic t_busy_ignore;
    int lat, acks, ack_at, dw, extra_done, extra_ack, extra_req; bit gd, gf;
    run_int(0, 0, 8'h09, 16'h9999, 16'hAAAA, 16'h0700, 16'h0500, 5, lat, gd, gf, acks, ack_at, dw);
    chk(acks == 0, "R8", "no ack while busy", 32'(acks), 32'd0);
    expect_entry("R8 busy ignore", 8'h09, 16'h9999, 16'hAAAA, 16'h0700, 16'h0500, lat, 11, gd);
    extra_done = 0; extra_ack = 0; extra_req = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done) extra_done++;
      if (hw_ack) extra_ack++;
      if (mem_req || busy) extra_req++;
    end
    chk(extra_done + extra_ack + extra_req == 0, "R8", "dropped requests leave no trace",
        32'(extra_done + extra_ack + extra_req), 32'd0);
  endtask

  initial begin
    for (int v = 0; v < 34; v++) put_entry(8'(v));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_soft();
    t_hard();
    t_both();
    t_boundary();
    t_fault();
    t_sp_wrap();
    t_phys_wrap();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule